// File: doc/BRIEF.md
# Regroupable Lookup-Table Function Unit

This block is a small configurable logic unit. It holds four 16-entry truth tables in one shared store and regroups them by a mode input. In quad mode the store acts as four separate 4-input lookup tables. In pair mode it acts as two 5-input tables. In wide mode those two halves are merged into a single wide function. Fourteen logic inputs enter the unit and five outputs leave it. Four flip-flops can each be switched in front of one of the four lower outputs, so those outputs can be registered or combinational.

Truth tables are loaded one 16-bit table per beat through a valid/ready configuration port. A beat is accepted on any rising edge where `cfg_valid` and `cfg_ready` are both high. `cfg_ready` is low only while reset is held, and it is high on every other cycle. A sender that sees `cfg_ready` low must hold its beat until ready returns. A written table takes effect on the combinational outputs in the cycle after the accepting edge. Mode, register selects and logic inputs are plain level inputs.

Top module: `mlut_unit`

## Requirements
- R1: While `rst` is sampled high at a rising edge, all four tables and all four output flip-flops clear to zero. With every table at zero, `y` is all zeros for any input pattern.
- R2: A beat accepted at an edge writes `cfg_data` into table `cfg_sel` (0 to 3). In table k, bit i is the output for address i. The new contents show on the outputs in the next cycle. Without an accepted beat, changes on `cfg_data` or `cfg_sel` leave every table unchanged.
- R3: Quad mode is `mode`=00. Outputs y[0], y[1] and y[2] read tables 0, 1 and 2 at addresses din[3:0], din[7:4] and din[11:8]. y[3] reads table 3 at address {din[13:12], din[1:0]}. y[4] is 0.
- R4: Pair mode is `mode`=01. Let a=din[3:0] and b=din[8:5]. P is table 1 at a when din[4]=1, and table 0 at a otherwise. Q is table 3 at b when din[9]=1, and table 2 at b otherwise. Then y[0]=T0[a], y[1]=T1[a], y[2]=T2[b], y[3]=Q and y[4]=P.
- R5: Wide mode is `mode`=10 or 11. The outputs are the same as pair mode, except that y[4] is Q when din[10]=1 and P when din[10]=0. This is a function of up to 11 inputs, din[10:0]. It becomes a full 6-input table when the same signals drive b and a.
- R6: When reg_sel[k]=1 (k from 0 to 3), y[k] shows the combinational value of output k captured at the previous rising edge. When reg_sel[k]=0, y[k] shows the combinational value directly. y[4] is always combinational.
- R7: `cfg_ready` is 0 while `rst` is 1 and 1 while `rst` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mode | input | 2 | Table grouping: 00 quad, 01 pair, 1x wide |
| reg_sel | input | 4 | Per-output choice of registered (1) or combinational (0) value for y[3:0] |
| din | input | 14 | Logic inputs |
| cfg_valid | input | 1 | Configuration beat present |
| cfg_ready | output | 1 | Configuration beat can be accepted |
| cfg_sel | input | 2 | Index of the table to write |
| cfg_data | input | 16 | Truth-table contents; bit i is the output for address i |
| y | output | 5 | Function outputs |

## Verification
The register-capture property assumes `reg_sel` is held steady across the edge it checks, so the bench changes `reg_sel` only between sweeps. The wide-mode property compares y[4] with y[3]. It therefore assumes output 3 is combinational, and it fires only when reg_sel[3] is 0. The write property assumes no beat is offered while reset is asserted. The bench keeps `cfg_valid` low for the whole reset window.

// File: rtl/mlut_pkg.sv
package mlut_pkg;
  localparam int TBL_N    = 4;
  localparam int TBL_AW   = 4;
  localparam int TBL_BITS = 1 << TBL_AW;
  localparam int SEL_W    = $clog2(TBL_N);
  localparam int IN_W     = 14;
  localparam int REG_N    = 4;
  localparam int OUT_W    = REG_N + 1;

  typedef enum logic [1:0] {
    MODE_QUAD = 2'b00,
    MODE_PAIR = 2'b01,
    MODE_WIDE = 2'b10
  } mode_e;
endpackage

// File: rtl/mlut_store.sv
module mlut_store #(
  parameter int N  = 4,
  parameter int AW = 4
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           wr_en,
  input  logic [$clog2(N)-1:0]           wr_sel,
  input  logic [(1<<AW)-1:0]             wr_data,
  output logic [N-1:0][(1<<AW)-1:0]      tbl
);
  localparam int SW = $clog2(N);

  always_ff @(posedge clk) begin
    if (rst) begin
      tbl <= '0;
    end else if (wr_en) begin
      for (int k = 0; k < N; k++) begin
        if (wr_sel == SW'(k)) tbl[k] <= wr_data;
      end
    end
  end
endmodule

// File: rtl/mlut_read.sv
module mlut_read #(
  parameter int N  = 4,
  parameter int AW = 4
) (
  input  logic [N-1:0][(1<<AW)-1:0] tbl,
  input  logic [N-1:0][AW-1:0]      addr,
  output logic [N-1:0]              bit_o
);
  for (genvar gi = 0; gi < N; gi++) begin : g_rd
    assign bit_o[gi] = tbl[gi][addr[gi]];
  end
endmodule

// File: rtl/mlut_outreg.sv
module mlut_outreg #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  input  logic [W-1:0] sel,
  output logic [W-1:0] q
);
  for (genvar gi = 0; gi < W; gi++) begin : g_ff
    logic held;
    always_ff @(posedge clk) begin
      if (rst) held <= 1'b0;
      else     held <= d[gi];
    end
    assign q[gi] = sel[gi] ? held : d[gi];
  end
endmodule

// File: rtl/mlut_unit.sv
module mlut_unit
  import mlut_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic [1:0]           mode,
  input  logic [REG_N-1:0]     reg_sel,
  input  logic [IN_W-1:0]      din,
  input  logic                 cfg_valid,
  output logic                 cfg_ready,
  input  logic [SEL_W-1:0]     cfg_sel,
  input  logic [TBL_BITS-1:0]  cfg_data,
  output logic [OUT_W-1:0]     y
);
  logic                              is_quad;
  logic                              is_wide;
  logic                              wr_en;
  logic [TBL_N-1:0][TBL_BITS-1:0]    tbl;
  logic [TBL_N-1:0][TBL_AW-1:0]      addr;
  logic [TBL_N-1:0]                  f;
  logic                              half_lo;
  logic                              half_hi;
  logic [OUT_W-1:0]                  y_comb;
  logic [REG_N-1:0]                  y_low;

  assign is_quad   = (mode == MODE_QUAD);
  assign is_wide   = mode[1];
  assign cfg_ready = ~rst;
  assign wr_en     = cfg_valid & cfg_ready;

  mlut_store #(.N(TBL_N), .AW(TBL_AW)) u_store (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_sel  (cfg_sel),
    .wr_data (cfg_data),
    .tbl     (tbl)
  );

  always_comb begin
    if (is_quad) begin
      addr[0] = din[3:0];
      addr[1] = din[7:4];
      addr[2] = din[11:8];
      addr[3] = {din[13:12], din[1:0]};
    end else begin
      addr[0] = din[3:0];
      addr[1] = din[3:0];
      addr[2] = din[8:5];
      addr[3] = din[8:5];
    end
  end

  mlut_read #(.N(TBL_N), .AW(TBL_AW)) u_read (
    .tbl   (tbl),
    .addr  (addr),
    .bit_o (f)
  );

  assign half_lo = din[4] ? f[1] : f[0];
  assign half_hi = din[9] ? f[3] : f[2];

  always_comb begin
    y_comb[2:0] = f[2:0];
    y_comb[3]   = is_quad ? f[3] : half_hi;
    if (is_quad)      y_comb[4] = 1'b0;
    else if (is_wide) y_comb[4] = din[10] ? half_hi : half_lo;
    else              y_comb[4] = half_lo;
  end

  mlut_outreg #(.W(REG_N)) u_oreg (
    .clk (clk),
    .rst (rst),
    .d   (y_comb[REG_N-1:0]),
    .sel (reg_sel),
    .q   (y_low)
  );

  assign y = {y_comb[OUT_W-1], y_low};
endmodule

// File: rtl/mlut_unit_chk.sv
module mlut_unit_chk (
  input logic        clk,
  input logic        rst,
  input logic [1:0]  mode,
  input logic [3:0]  reg_sel,
  input logic [13:0] din,
  input logic        cfg_valid,
  input logic        cfg_ready,
  input logic [1:0]  cfg_sel,
  input logic [15:0] cfg_data,
  input logic [4:0]  y,
  input logic [4:0]  y_comb,
  input logic [63:0] tbl
);
  // R2: an accepted beat lands in the addressed table
  a_r2_write_lands: assert property (@(posedge clk) disable iff (rst)
    (cfg_valid && cfg_ready) |=> tbl[$past(cfg_sel)*16 +: 16] == $past(cfg_data));

  // R2: no accepted beat, no table change
  a_r2_hold_without_beat: assert property (@(posedge clk) disable iff (rst)
    !(cfg_valid && cfg_ready) |=> $stable(tbl));

  // R3: quad mode drives the fifth output low
  a_r3_quad_fifth_low: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b00) |-> (y[4] == 1'b0));

  // R5: wide mode with din[10] set follows the upper half (seen on y[3])
  a_r5_wide_upper_half: assert property (@(posedge clk) disable iff (rst)
    (mode[1] && din[10] && !reg_sel[3]) |-> (y[4] == y[3]));

  // R6: registered outputs show last edge's combinational value
  a_r6_reg_capture: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && reg_sel == $past(reg_sel))
      |-> (((y[3:0] ^ $past(y_comb[3:0])) & reg_sel) == 4'b0));

  // R1: flip-flops are cleared by reset
  a_r1_regs_cleared: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> ((y[3:0] & reg_sel) == 4'b0));
endmodule

bind mlut_unit mlut_unit_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .mode      (mode),
  .reg_sel   (reg_sel),
  .din       (din),
  .cfg_valid (cfg_valid),
  .cfg_ready (cfg_ready),
  .cfg_sel   (cfg_sel),
  .cfg_data  (cfg_data),
  .y         (y),
  .y_comb    (y_comb),
  .tbl       (tbl)
);

// File: tb/sim_mlut_unit.sv
module sim_mlut_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  mode = 2'b00;
  logic [3:0]  reg_sel = 4'b0000;
  logic [13:0] din = '0;
  logic        cfg_valid = 1'b0;
  logic        cfg_ready;
  logic [1:0]  cfg_sel = 2'b00;
  logic [15:0] cfg_data = '0;
  logic [4:0]  y;

  int n_chk = 0;
  int n_fail = 0;
  bit cmp_on = 1'b0;

  logic [15:0] mtbl [4];
  logic [3:0]  mq;

  always #(CLK_PERIOD/2) clk = ~clk;

  mlut_unit u0 (
    .clk (clk), .rst (rst), .mode (mode), .reg_sel (reg_sel), .din (din),
    .cfg_valid (cfg_valid), .cfg_ready (cfg_ready), .cfg_sel (cfg_sel),
    .cfg_data (cfg_data), .y (y)
  );

  function automatic logic [4:0] model_comb();
    logic [4:0] r;
    logic p, q;
    int a, b;
    a = int'(din[3:0]);
    b = int'(din[8:5]);
    if (mode == 2'b00) begin
      r[0] = mtbl[0][din[3:0]];
      r[1] = mtbl[1][din[7:4]];
      r[2] = mtbl[2][din[11:8]];
      r[3] = mtbl[3][{din[13:12], din[1:0]}];
      r[4] = 1'b0;
    end else begin
      p = din[4] ? mtbl[1][a] : mtbl[0][a];
      q = din[9] ? mtbl[3][b] : mtbl[2][b];
      r[0] = mtbl[0][a];
      r[1] = mtbl[1][a];
      r[2] = mtbl[2][b];
      r[3] = q;
      if (mode == 2'b01) r[4] = p;
      else               r[4] = din[10] ? q : p;
    end
    return r;
  endfunction

  function automatic logic [4:0] model_out();
    logic [4:0] c;
    c = model_comb();
    return {c[4], (mq & reg_sel) | (c[3:0] & ~reg_sel)};
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      mq <= 4'b0;
      for (int k = 0; k < 4; k++) mtbl[k] <= 16'h0;
    end else begin
      mq <= model_comb()[3:0];
      if (cfg_valid) mtbl[cfg_sel] <= cfg_data;
    end
  end

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h (mode=%b reg_sel=%b din=%h)",
               req, act, exp, mode, reg_sel, din);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on && !rst) begin
      string tag;
      if (mode == 2'b00)      tag = "R3";
      else if (mode == 2'b01) tag = "R4";
      else                    tag = "R5";
      if (reg_sel != 4'b0) tag = {tag, "/R6"};
      check(tag, 16'(y), 16'(model_out()));
    end
  end

  task automatic load_tbl(int k, logic [15:0] v);
    @(negedge clk); #1;
    cfg_valid = 1'b1; cfg_sel = 2'(k); cfg_data = v;
    @(negedge clk); #1;
    cfg_valid = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R1 watchdog: actual=still running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R7", 16'(cfg_ready), 16'h0);
    din = 14'h3fff; reg_sel = 4'b1111;
    @(negedge clk);
    check("R1", 16'(y), 16'h0);
    #1 rst = 1'b0; reg_sel = 4'b0000; mode = 2'b10;
    @(negedge clk);
    check("R7", 16'(cfg_ready), 16'h1);
    check("R1", 16'(y), 16'h0);
    #1 mode = 2'b00; din = '0;

    // R2: write table 0 all ones, visible next cycle on y[0]
    load_tbl(0, 16'hffff);
    @(negedge clk);
    check("R2", 16'(y[0]), 16'h1);
    #1 cfg_data = 16'h0000; cfg_sel = 2'b00;
    @(negedge clk);
    check("R2", 16'(y[0]), 16'h1);
    #1 din = 14'h0001;
    @(negedge clk);
    check("R2", 16'(y[0]), 16'h1);

    cmp_on = 1'b1;
    for (int m = 0; m < 3; m++) begin
      for (int s = 0; s < 2; s++) begin
        @(negedge clk); #1;
        mode = 2'(m);
        reg_sel = (s == 0) ? 4'b0101 : 4'b1010;
        for (int k = 0; k < 4; k++) load_tbl(k, 16'($urandom));
        for (int p = 0; p < 16384; p++) begin
          @(negedge clk); #1;
          din = 14'(p);
        end
      end
    end

    // R5: encoding 11 also selects wide mode
    @(negedge clk); #1;
    mode = 2'b11; reg_sel = 4'b0000;
    for (int p = 0; p < 2048; p++) begin
      @(negedge clk); #1;
      din = 14'($urandom);
    end

    // R1: reset mid-run clears flip-flops and tables
    @(negedge clk); #1;
    cmp_on = 1'b0; reg_sel = 4'b1111; mode = 2'b01; din = 14'h3fff;
    rst = 1'b1;
    @(negedge clk);
    check("R7", 16'(cfg_ready), 16'h0);
    #1 rst = 1'b0;
    @(negedge clk);
    check("R1", 16'(y[3:0]), 16'h0);
    #1 reg_sel = 4'b0000;
    for (int p = 0; p < 64; p++) begin
      @(negedge clk); #1;
      din = 14'($urandom);
      mode = 2'(p % 3);
      @(negedge clk);
      check("R1", 16'(y), 16'h0);
    end
    finish_run();
  end
endmodule